// File: doc/BRIEF.md
# Dual Maskable Alarm Interrupt Unit

This block watches a running time of day and raises interrupts when it reaches one of two programmed alarm points. The time counters sit outside the block. They present the current seconds, minutes, hours and day-of-week values, each as a 7-bit BCD field. They also pulse a one-cycle tick once the counters have advanced to a new second. On every tick, each alarm compares its four stored fields against the time. Any field whose don't-care bit is set takes no part in that comparison. A full match latches that alarm's request flag.

The flags drive two active-low interrupt lines. Each line comes as a level and an output enable, so that together they model an open-drain pin. Each alarm has its own enable. A routing bit chooses the mode:
- Split mode: each alarm owns one line.
- Merged mode: both alarms share line 0, and line 1 stays idle.

A host reaches the eight alarm registers and one control register through a small address, read-strobe and write-strobe port. Any read or write of one alarm's registers clears that alarm's flag. The interrupt service routine therefore acknowledges an alarm simply by touching that alarm's registers.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, every alarm register and the control register hold 0, both flags are 0, and both lines are inactive (irq_n_o = 2'b11, irq_oe_o = 2'b00).
- R2: Address 0..3 hold alarm 0 and address 4..7 hold alarm 1. Within each alarm, the field order is seconds, minutes, hours, day. Address 8 is control, with bit 0 = enable 0, bit 1 = enable 1 and bit 2 = split routing; its bits 7..3 read 0. rdata_o shows the addressed register combinationally. Addresses 9..15 read 0, and writes to them have no effect.
- R3: In each alarm register, bit 7 is a don't-care mask and bits 6..0 are the compare value, checked for equality against the 7-bit time input. An alarm matches when every unmasked field is equal.
- R4: A flag is set only in a cycle with tick_i high and a match. It appears on flag_o one cycle after that edge. With tick_i low, a matching time sets nothing.
- R5: A set flag holds until a read or write of any of its own alarm's four registers, and it reads 0 from the cycle after that access. Accesses to the other alarm or to control leave it unchanged.
- R6: When a tick with a match and an access to that alarm's registers fall in the same cycle, the flag ends up set.
- R7: In split mode (routing = 1), line 0 is active when flag 0 and enable 0 are both set. Line 1 is active when flag 1 and enable 1 are both set.
- R8: In merged mode (routing = 0), line 0 is active when flag 0 and enable 0 are both set, or when flag 1 and enable 1 are both set. Line 1 is never active in this mode.
- R9: An active line drives irq_n_o = 0 with irq_oe_o = 1, and an inactive line drives 1 with 0. Lines follow the flags and the control register with no extra register stage.
- R10: The alarm hours value includes bit 6 (12-hour mode) and bit 5 (PM), so 12 PM in 12-hour form matches only the identical hours code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second, time inputs already updated |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD with 12/24 and PM bits |
| day_i | input | 7 | Current day of week |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| flag_o | output | 2 | Alarm request flags, bit k for alarm k |
| irq_n_o | output | 2 | Active-low interrupt levels |
| irq_oe_o | output | 2 | Interrupt output enables (high when pulling low) |

## Verification
The bench runs all 16 mask patterns of alarm 0 against all 16 patterns of which fields differ from the alarm values. A comparator that ignored a mask, or inverted it, would raise flags at the wrong cadence. It then runs every combination of routing bit, the two enables and the two flags. A router that leaked alarm 1 onto line 1 in merged mode, or ignored an enable, would drive the wrong line. Targeted cases check three further behaviours:
- A tick and a clearing read in the same cycle must leave the flag set.
- An access to one alarm must not clear the other alarm's flag.
- A 12 AM hours code must not match a 12 PM alarm.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W   = 8;
  localparam int FIELDS   = 4;
  localparam int N_ALARM  = 2;
  localparam int ADDR_W   = 4;
  localparam int CTRL_W   = 3;

  typedef struct packed {
    logic       route;  // 1: split lines, 0: merged onto line 0
    logic [1:0] en;
  } ctrl_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] alarm_i,
  input  logic [DW-2:0] time_i,
  output logic          hit_o
);
  // msb is the don't-care mask
  assign hit_o = alarm_i[DW-1] | (alarm_i[DW-2:0] == time_i);
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank #(
  parameter int DW     = 8,
  parameter int FIELDS = 4,
  localparam int IDX_W = $clog2(FIELDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic [FIELDS-1:0][DW-2:0]    time_i,
  input  logic                         wr_i,
  input  logic                         acc_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  output logic                         flag_o
);
  logic [FIELDS-1:0][DW-1:0] alm_q;
  logic [FIELDS-1:0]         hit;
  logic                      match;
  logic                      flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
    end else if (wr_i) begin
      alm_q[idx_i] <= wdata_i;
    end
  end

  for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
    alarm_field_cmp #(.DW(DW)) u_cmp (
      .alarm_i (alm_q[f]),
      .time_i  (time_i[f]),
      .hit_o   (hit[f])
    );
  end

  assign match = &hit;

  // a fresh match beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (tick_i && match) begin
      flag_q <= 1'b1;
    end else if (acc_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign rdata_o = alm_q[idx_i];
endmodule

// File: rtl/irq_route.sv
module irq_route (
  input  logic [1:0] flag_i,
  input  logic [1:0] en_i,
  input  logic       route_i,
  output logic [1:0] active_o
);
  logic [1:0] req;

  assign req = flag_i & en_i;

  always_comb begin
    if (route_i) begin
      active_o = req;
    end else begin
      active_o = {1'b0, |req};
    end
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NF     = FIELDS,
  parameter int AW     = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-2:0] sec_i,
  input  logic [DW-2:0] min_i,
  input  logic [DW-2:0] hour_i,
  input  logic [DW-2:0] day_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    flag_o,
  output logic [1:0]    irq_n_o,
  output logic [1:0]    irq_oe_o
);
  localparam int IDX_W = $clog2(NF);
  localparam int BNK_W = AW - IDX_W;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_ALARM * NF);

  logic [NF-1:0][DW-2:0]      time_w;
  logic [N_ALARM-1:0]         sel;
  logic [N_ALARM-1:0][DW-1:0] bank_rd;
  logic [1:0]                 active;
  logic                       ctrl_sel;
  logic                       route_w;
  ctrl_t                      ctrl_q;

  assign time_w[0] = sec_i;
  assign time_w[1] = min_i;
  assign time_w[2] = hour_i;
  assign time_w[3] = day_i;

  assign ctrl_sel = (addr_i == CTRL_ADDR);

  for (genvar k = 0; k < N_ALARM; k++) begin : g_bank
    assign sel[k] = (addr_i[AW-1:IDX_W] == BNK_W'(k));
    alarm_bank #(.DW(DW), .FIELDS(NF)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .time_i  (time_w),
      .wr_i    (wr_en_i & sel[k]),
      .acc_i   ((wr_en_i | rd_en_i) & sel[k]),
      .idx_i   (addr_i[IDX_W-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[k]),
      .flag_o  (flag_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && ctrl_sel) begin
      ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_ALARM; k++) begin
      if (sel[k]) rdata_o = bank_rd[k];
    end
    if (ctrl_sel) rdata_o = DW'(ctrl_q);
  end

  irq_route u_route (
    .flag_i   (flag_o),
    .en_i     (ctrl_q.en),
    .route_i  (ctrl_q.route),
    .active_o (active)
  );

  assign route_w  = ctrl_q.route;
  assign irq_n_o  = ~active;
  assign irq_oe_o = active;
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
  parameter int AW = 4,
  parameter int NF = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    flag_o,
  input logic [1:0]    irq_n_o,
  input logic [1:0]    irq_oe_o,
  input logic          route_i
);
  logic acc0, acc1;
  assign acc0 = (wr_en_i | rd_en_i) && (int'(addr_i) < NF);
  assign acc1 = (wr_en_i | rd_en_i) && (int'(addr_i) >= NF) && (int'(addr_i) < 2 * NF);

  assert_hold0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !acc0) |=> flag_o[0]);
  assert_hold1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !acc1) |=> flag_o[1]);
  assert_clear0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc0 && !tick_i) |=> !flag_o[0]);
  assert_notick0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o[0] && !tick_i) |=> !flag_o[0]);
  assert_notick1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o[1] && !tick_i) |=> !flag_o[1]);
  assert_polarity_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_o == ~irq_oe_o);
  assert_line1_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_i |-> !irq_oe_o[1]);
  assert_line1_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o[1] |-> flag_o[1]);
  assert_line0_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o[0] |-> (flag_o != 2'b00));
endmodule

bind alarm_irq_unit alarm_irq_chk #(.AW(AW), .NF(NF)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .flag_o   (flag_o),
  .irq_n_o  (irq_n_o),
  .irq_oe_o (irq_oe_o),
  .route_i  (route_w)
);

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] sec = '0, mins = '0, hour = '0, day = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] flag, irq_n, irq_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alarm_irq_unit dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .tick_i (tick),
    .sec_i (sec), .min_i (mins), .hour_i (hour), .day_i (day),
    .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .flag_o (flag), .irq_n_o (irq_n), .irq_oe_o (irq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, released at next negedge
  task automatic step(input bit tk, input bit wr, input bit rd,
                      input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = tk; wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 q = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_time(input logic [6:0] s, m, h, dy);
    sec = s; mins = m; hour = h; day = dy;
  endtask

  initial begin
    logic [7:0] q;
    logic [6:0] av [4];
    logic [6:0] alt [4];
    av[0] = 7'h30; av[1] = 7'h15; av[2] = 7'h08; av[3] = 7'h03;
    alt[0] = 7'h31; alt[1] = 7'h16; alt[2] = 7'h09; alt[3] = 7'h05;

    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", {6'b0, irq_n}, 8'h03);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", {6'b0, flag}, 8'h00);
    chk("R1 irq_oe after reset", {6'b0, irq_oe}, 8'h00);
    rd(4'd2, q); chk("R1 alarm reg reset", q, 8'h00);
    rd(4'd8, q); chk("R1 control reset", q, 8'h00);

    // R2 readback
    for (int i = 0; i < 8; i++) wr(4'(i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), q); chk("R2 alarm readback", q, 8'(8'h11 * (i + 1)));
    end
    wr(4'd8, 8'hff); rd(4'd8, q); chk("R2 control upper bits zero", q, 8'h07);
    wr(4'd12, 8'h5a); rd(4'd12, q); chk("R2 unmapped reads zero", q, 8'h00);
    rd(4'd8, q); chk("R2 unmapped write no effect", q, 8'h07);
    wr(4'd8, 8'h00);
    for (int i = 4; i < 8; i++) wr(4'(i), 8'h00); // alarm 1 never matches (day 0)

    // R3 sweep: mask pattern x differing-field pattern
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 4; f++) wr(4'(f), {m[f], av[f]});
      for (int d = 0; d < 16; d++) begin
        set_time(d[0] ? alt[0] : av[0], d[1] ? alt[1] : av[1],
                 d[2] ? alt[2] : av[2], d[3] ? alt[3] : av[3]);
        step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
        chk("R3 masked match flag0", {7'b0, flag[0]}, {7'b0, ((~m & d & 15) == 0)});
        chk("R3 alarm1 untouched", {7'b0, flag[1]}, 8'h00);
        rd(4'd0, q);
      end
    end
    // R10 all masked alarm fires on any time
    set_time(7'h59, 7'h42, 7'h23, 7'h07);
    for (int f = 0; f < 4; f++) wr(4'(f), 8'h80);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 all masked fires every tick", {6'b0, flag}, 8'h01);
    rd(4'd0, q);

    // R10 12-hour PM bits compared
    wr(4'd2, 8'h72);
    set_time(7'h00, 7'h00, 7'h72, 7'h01);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 12PM matches 12PM", {6'b0, flag}, 8'h01);
    rd(4'd0, q);
    set_time(7'h00, 7'h00, 7'h52, 7'h01);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 12AM not 12PM", {6'b0, flag}, 8'h00);
    set_time(7'h00, 7'h00, 7'h12, 7'h01);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 24h 12 not 12PM", {6'b0, flag}, 8'h00);
    wr(4'd2, 8'h80);

    // R4 matching time without tick
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R4 no tick no set", {6'b0, flag}, 8'h00);
    // R4 latency: flag low before edge, high after
    @(negedge clk); tick = 1'b1;
    #1 chk("R4 not yet set before edge", {6'b0, flag}, 8'h00);
    @(negedge clk); tick = 1'b0;
    chk("R4 set one cycle after tick", {6'b0, flag}, 8'h01);
    // R6 same-cycle tick and read
    step(1'b1, 1'b0, 1'b1, 4'd1, 8'h00);
    chk("R6 set beats clear", {6'b0, flag}, 8'h01);
    step(1'b0, 1'b1, 1'b0, 4'd3, 8'h80);
    chk("R5 write clears own flag", {6'b0, flag}, 8'h00);

    // R7 R8 R9 routing sweep, both alarms all masked
    for (int f = 0; f < 8; f++) wr(4'(f), 8'h80);
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic a0, a1, i0, i1;
        wr(4'd8, 8'(c));
        step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
        if (!p[0]) rd(4'd0, q);
        if (!p[1]) rd(4'd4, q);
        chk("R5 other alarm access keeps flag", {6'b0, flag}, 8'(p));
        a0 = p[0] & c[0]; a1 = p[1] & c[1];
        i0 = c[2] ? a0 : (a0 | a1);
        i1 = c[2] & a1;
        if (c[2]) begin
          chk("R7 split irq_oe", {6'b0, irq_oe}, {6'b0, i1, i0});
        end else begin
          chk("R8 merged irq_oe", {6'b0, irq_oe}, {6'b0, i1, i0});
        end
        chk("R9 active low level", {6'b0, irq_n}, {6'b0, ~i1, ~i0});
        rd(4'd0, q); rd(4'd4, q);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule